// File: doc/BRIEF.md
# PCI 64-bit Target Width Negotiator

This block sits on the target side of a PCI bus interface. Once a transaction has been claimed, it decides whether the data phases use the 64-bit extension. It answers the initiator's 64-bit request in the same cycle that it claims the transaction. It then runs the data phases at the chosen width. On wide read phases it produces the upper-half parity. When a wide read would otherwise end on an unpaired dword, it ends the transfer early with a disconnect.

Address decode, the forwarding buffers and the master on the far side are not part of this block. Each claimed transaction arrives as a one-cycle `start_i` pulse. The pulse carries a command class, the initiator's 64-bit request and, for memory reads, the number of dwords already held in the read buffer. That count must be at least 1. The block always holds TRDY while a transaction is open. A data phase completes on every clock in which IRDY is high.

Top module: `pci64_target_width`

## Requirements
- R1: `ack64_o` is high only while `devsel_o` is high, and it keeps one value for the whole of a transaction. `devsel_o` and `trdy_o` rise one clock after an accepted `start_i`.
- R2: If `req64_i` is low at `start_i`, `ack64_o` stays low for that transaction.
- R3: `ack64_o` stays low for the non-prefetchable memory read class (`cmd_i`=1), the I/O class (3) and the configuration class (4). It is granted for a memory write (2) when `req64_i` is high.
- R4: `ack64_o` stays low for a prefetchable memory read (`cmd_i`=0) whose buffered count `rd_cnt_i` is below 2.
- R5: For a granted memory write, every data phase is a 64-bit phase (`ack64_o` high). Writes, I/O and configuration transactions never assert `stop_o` or `ad_hi_oe_o`.
- R6: For a granted prefetchable read, `ad_hi_oe_o` is high in every data cycle and each completed phase consumes two buffered dwords.
- R7: One clock after each completed 64-bit read phase, `par64_oe_o` is high for that one clock. In that clock `par64_o` equals the XOR of `ad_hi_i` and `cbe_hi_i` as sampled in the phase, which gives even parity. At all other times `par64_oe_o` is low.
- R8: In a granted read with N buffered dwords, `stop_o` is high together with `trdy_o` on phase N/2 (integer division), and the transaction ends after that phase. An odd trailing dword is never returned.
- R9: Without a grant, memory reads run 32-bit phases, with `ad_hi_oe_o` and `par64_oe_o` low. `stop_o` is raised on phase N, so N phases are delivered.
- R10: A completed phase with `frame_i` low ends the transaction: `devsel_o` is low one clock later.
- R11: A `start_i` pulse while a transaction is open is ignored, and the open transaction keeps its width and length.
- R12: While reset is held and just after it, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse: a transaction has been claimed |
| cmd_i | input | 3 | Command class, valid with start_i (0 PF read, 1 NP read, 2 write, 3 I/O, 4 config) |
| req64_i | input | 1 | Initiator's 64-bit request, valid with start_i |
| rd_cnt_i | input | CNT_W | Buffered read dwords, valid with start_i |
| frame_i | input | 1 | Initiator still has phases to run (high) or is on its last phase (low) |
| irdy_i | input | 1 | Initiator ready; a phase completes when high |
| ad_hi_i | input | 32 | Upper AD half as driven in the current phase |
| cbe_hi_i | input | 4 | Upper byte enables as driven in the current phase |
| devsel_o | output | 1 | Transaction claimed and open |
| trdy_o | output | 1 | Target ready |
| stop_o | output | 1 | Disconnect with the current phase |
| ack64_o | output | 1 | 64-bit phases granted |
| ad_hi_oe_o | output | 1 | Target drives the upper AD half |
| par64_o | output | 1 | Upper-half parity |
| par64_oe_o | output | 1 | Target drives upper-half parity |

## Verification
The assertions check a set of rules on every cycle. The grant stays inside DEVSEL and holds steady for the whole transaction. No grant follows a start without a request, with an excluded class, or with a short prefetchable read. The upper AD half is only driven under a grant. Parity appears only one clock after a wide read phase. A disconnected phase always closes the transaction. Other properties need the bench's own scenarios to show them: the exact phase on which the disconnect falls for odd and even counts, the parity values, 32-bit reads delivering every dword, early termination by FRAME, and starts that are ignored.

// File: rtl/pci64_neg_pkg.sv
package pci64_neg_pkg;
  typedef enum logic [2:0] {
    CLS_MRD_PF = 3'd0,
    CLS_MRD_NP = 3'd1,
    CLS_MWR    = 3'd2,
    CLS_IO     = 3'd3,
    CLS_CFG    = 3'd4
  } cmd_class_e;
endpackage

// File: rtl/pci64_width_decide.sv
module pci64_width_decide
  import pci64_neg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [2:0]       cmd_i,
  input  logic             req64_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             grant_o,
  output logic             mem_rd_o
);
  localparam logic [CNT_W-1:0] MIN_PAIR = CNT_W'(2);

  logic is_pf_rd;
  logic is_wr;

  always_comb begin
    is_pf_rd = (cmd_i == CLS_MRD_PF);
    is_wr    = (cmd_i == CLS_MWR);
    mem_rd_o = is_pf_rd || (cmd_i == CLS_MRD_NP);
    // Wide only on request, and only for writes or pf reads that hold a pair
    grant_o  = req64_i && (is_wr || (is_pf_rd && (cnt_i >= MIN_PAIR)));
  end
endmodule

// File: rtl/pci64_phase_ctl.sv
module pci64_phase_ctl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             grant_i,
  input  logic             mem_rd_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             irdy_i,
  input  logic             frame_i,
  output logic             active_o,
  output logic             wide_o,
  output logic             rd_o,
  output logic             stop_o,
  output logic             phase_done_o
);
  localparam logic [CNT_W-1:0] STEP_WIDE   = CNT_W'(2);
  localparam logic [CNT_W-1:0] STEP_NARROW = CNT_W'(1);
  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(4);
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(2);

  logic             active_q, active_d;
  logic             wide_q, wide_d;
  logic             rd_q, rd_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             load_en;
  logic             last_ph;

  always_comb begin
    load_en      = start_i && !active_q;
    phase_done_o = active_q && irdy_i;
    // Stop on the last phase that still holds a full unit of the chosen width
    last_ph      = rd_q && (wide_q ? (rem_q < LAST_WIDE) : (rem_q < LAST_NARROW));

    active_d = active_q;
    wide_d   = wide_q;
    rd_d     = rd_q;
    rem_d    = rem_q;
    if (load_en) begin
      active_d = 1'b1;
      wide_d   = grant_i;
      rd_d     = mem_rd_i;
      rem_d    = cnt_i;
    end else if (phase_done_o) begin
      rem_d = rem_q - (wide_q ? STEP_WIDE : STEP_NARROW);
      if (last_ph || !frame_i) begin
        active_d = 1'b0;
        wide_d   = 1'b0;
        rd_d     = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wide_q   <= 1'b0;
      rd_q     <= 1'b0;
      rem_q    <= '0;
    end else begin
      active_q <= active_d;
      wide_q   <= wide_d;
      rd_q     <= rd_d;
      rem_q    <= rem_d;
    end
  end

  assign active_o = active_q;
  assign wide_o   = active_q && wide_q;
  assign rd_o     = active_q && rd_q;
  assign stop_o   = active_q && last_ph;

  // R8: a phase taken together with a disconnect closes the transaction
  p_stop_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_o && irdy_i) |=> !active_o);

  // R10: a final phase marked by frame closes the transaction
  p_frame_closes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && irdy_i && !frame_i) |=> !active_o);
endmodule

// File: rtl/pci64_par64_gen.sv
module pci64_par64_gen #(
  parameter int HI_W = 32,
  parameter int BE_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic [HI_W-1:0] hi_i,
  input  logic [BE_W-1:0] be_i,
  output logic            par_o,
  output logic            oe_o
);
  logic par_q, par_d;
  logic oe_q, oe_d;

  always_comb begin
    oe_d  = en_i;
    par_d = par_q;
    if (en_i) par_d = ^{hi_i, be_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      par_q <= par_d;
      oe_q  <= oe_d;
    end
  end

  assign par_o = oe_q && par_q;
  assign oe_o  = oe_q;
endmodule

// File: rtl/pci64_target_width.sv
module pci64_target_width
  import pci64_neg_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int HI_W  = 32,
  parameter int BE_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [2:0]       cmd_i,
  input  logic             req64_i,
  input  logic [CNT_W-1:0] rd_cnt_i,
  input  logic             frame_i,
  input  logic             irdy_i,
  input  logic [HI_W-1:0]  ad_hi_i,
  input  logic [BE_W-1:0]  cbe_hi_i,
  output logic             devsel_o,
  output logic             trdy_o,
  output logic             stop_o,
  output logic             ack64_o,
  output logic             ad_hi_oe_o,
  output logic             par64_o,
  output logic             par64_oe_o
);
  logic grant;
  logic mem_rd;
  logic active;
  logic wide;
  logic rd_open;
  logic phase_done;
  logic par_en;

  pci64_width_decide #(.CNT_W(CNT_W)) u_decide (
    .cmd_i    (cmd_i),
    .req64_i  (req64_i),
    .cnt_i    (rd_cnt_i),
    .grant_o  (grant),
    .mem_rd_o (mem_rd)
  );

  pci64_phase_ctl #(.CNT_W(CNT_W)) u_phase (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .grant_i      (grant),
    .mem_rd_i     (mem_rd),
    .cnt_i        (rd_cnt_i),
    .irdy_i       (irdy_i),
    .frame_i      (frame_i),
    .active_o     (active),
    .wide_o       (wide),
    .rd_o         (rd_open),
    .stop_o       (stop_o),
    .phase_done_o (phase_done)
  );

  assign par_en = phase_done && wide && rd_open;

  pci64_par64_gen #(.HI_W(HI_W), .BE_W(BE_W)) u_par (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (par_en),
    .hi_i  (ad_hi_i),
    .be_i  (cbe_hi_i),
    .par_o (par64_o),
    .oe_o  (par64_oe_o)
  );

  assign devsel_o   = active;
  assign trdy_o     = active;
  assign ack64_o    = wide;
  assign ad_hi_oe_o = wide && rd_open;

  // R1: grant only inside the claim, constant across it
  p_ack_in_devsel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ack64_o |-> devsel_o);
  p_ack_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (devsel_o && $past(devsel_o)) |-> $stable(ack64_o));

  // R2: no request, no grant
  p_no_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !devsel_o && !req64_i) |=> !ack64_o);

  // R3: excluded classes never get the wide path
  p_excluded_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !devsel_o && (cmd_i == CLS_MRD_NP || cmd_i == CLS_IO || cmd_i == CLS_CFG))
    |=> !ack64_o);

  // R4: a prefetchable read without a full dword pair stays narrow
  p_short_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !devsel_o && cmd_i == CLS_MRD_PF && rd_cnt_i < CNT_W'(2)) |=> !ack64_o);

  // R9: upper half only driven under a grant
  p_hi_oe_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ad_hi_oe_o |-> ack64_o);

  // R7: parity enable only after a completed wide read phase
  p_par_after_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    par64_oe_o |-> $past(ad_hi_oe_o && irdy_i));
endmodule

// File: tb/pci64_target_width_tb.sv
module pci64_target_width_tb;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start_i;
  logic [2:0]       cmd_i;
  logic             req64_i;
  logic [CNT_W-1:0] rd_cnt_i;
  logic             frame_i;
  logic             irdy_i;
  logic [31:0]      ad_hi_i;
  logic [3:0]       cbe_hi_i;
  logic devsel_o, trdy_o, stop_o, ack64_o, ad_hi_oe_o, par64_o, par64_oe_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pci64_target_width #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i), .req64_i(req64_i),
    .rd_cnt_i(rd_cnt_i), .frame_i(frame_i), .irdy_i(irdy_i), .ad_hi_i(ad_hi_i),
    .cbe_hi_i(cbe_hi_i), .devsel_o(devsel_o), .trdy_o(trdy_o), .stop_o(stop_o),
    .ack64_o(ack64_o), .ad_hi_oe_o(ad_hi_oe_o), .par64_o(par64_o), .par64_oe_o(par64_oe_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_grant(input int cmd, input bit req, input int cnt);
    return req && (cmd == 2 || (cmd == 0 && cnt >= 2));
  endfunction

  function automatic int exp_phases(input bit grant, input int cnt);
    return grant ? cnt / 2 : cnt;
  endfunction

  // cmd, req64, cnt; nph = phases before frame goes low (0 = never for reads);
  // dbl = pulse a second start during the first data cycle
  task automatic run_txn(input int cmd, input bit req, input int cnt, input int nph,
                         input bit dbl);
    bit g = exp_grant(cmd, req, cnt);
    bit rd = (cmd == 0 || cmd == 1);
    int rem = cnt;
    int ph = 0;
    bit fin = 0;
    bit pend = 0;
    bit ppar = 0;
    bit first = 1;
    bit stp;
    @(negedge clk);
    start_i = 1; cmd_i = 3'(cmd); req64_i = req; rd_cnt_i = CNT_W'(cnt);
    frame_i = 1; irdy_i = 0;
    forever begin
      @(negedge clk);
      start_i = 0;
      chk("R7 par64_oe", int'(par64_oe_o), int'(pend));
      if (pend) chk("R7 par64 value", int'(par64_o), int'(ppar));
      pend = 0;
      if (fin) begin
        chk("R10/R8 devsel closed", int'(devsel_o), 0);
        if (rd && nph == 0) chk("R8/R9 phase count", ph, exp_phases(g, cnt));
        break;
      end
      chk("R1 devsel", int'(devsel_o), 1);
      chk("R1 trdy", int'(trdy_o), 1);
      chk("R2/R3/R4/R5 ack64", int'(ack64_o), int'(g));
      stp = rd && (g ? rem < 4 : rem < 2);
      chk("R8/R9 stop", int'(stop_o), int'(stp));
      chk("R6/R9 ad_hi_oe", int'(ad_hi_oe_o), int'(rd && g));
      irdy_i = ($urandom_range(0, 3) != 0);
      ad_hi_i = $urandom;
      cbe_hi_i = 4'($urandom);
      frame_i = !(nph != 0 && ph == nph - 1);
      if (first && dbl) begin
        start_i = 1; cmd_i = 3'(g ? 1 : 2); req64_i = 1; rd_cnt_i = 8'd9;
      end
      first = 0;
      @(posedge clk);
      if (irdy_i) begin
        ph++;
        if (rd && g) begin pend = 1; ppar = ^{ad_hi_i, cbe_hi_i}; end
        rem -= g ? 2 : 1;
        if (stp || !frame_i) fin = 1;
      end
    end
    irdy_i = 0; frame_i = 1;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; start_i = 0; cmd_i = 0; req64_i = 0; rd_cnt_i = 0;
    frame_i = 1; irdy_i = 0; ad_hi_i = 0; cbe_hi_i = 0;
    repeat (3) @(negedge clk);
    chk("R12 devsel reset", int'(devsel_o), 0);
    chk("R12 ack64 reset", int'(ack64_o), 0);
    chk("R12 stop reset", int'(stop_o), 0);
    chk("R12 par64_oe reset", int'(par64_oe_o), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R12 idle after reset", int'(trdy_o | ad_hi_oe_o | par64_o), 0);

    run_txn(0, 1, 1, 0, 0);   // R4 single dword
    run_txn(0, 1, 2, 0, 0);   // R6 one wide phase
    run_txn(0, 1, 3, 0, 0);   // R8 odd: one phase, trailing dword dropped
    run_txn(0, 1, 7, 0, 0);   // R8 odd
    run_txn(0, 1, 8, 0, 0);   // R8 even
    run_txn(0, 0, 6, 0, 0);   // R2 no request
    run_txn(1, 1, 4, 0, 0);   // R3 NP read, R9
    run_txn(3, 1, 0, 2, 0);   // R3 I/O
    run_txn(4, 1, 0, 1, 0);   // R3 config
    run_txn(2, 1, 0, 4, 0);   // R5 wide write
    run_txn(2, 0, 0, 3, 0);   // R2 narrow write
    run_txn(0, 1, 12, 2, 0);  // R10 early end on wide read
    run_txn(0, 1, 6, 0, 1);   // R11 second start ignored
    run_txn(1, 0, 3, 0, 1);   // R11 second start ignored

    for (int i = 0; i < 150; i++) begin
      int c = $urandom_range(0, 4);
      bit rq = 1'($urandom);
      int n = $urandom_range(1, 11);
      int np = (c == 0 || c == 1) ? (($urandom_range(0, 3) == 0) ? $urandom_range(1, 3) : 0)
                                  : $urandom_range(1, 4);
      run_txn(c, rq, n, np, ($urandom_range(0, 7) == 0));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule